// File: doc/BRIEF.md
# Programmable Logic Input Capture Cell Bank

This block is a bank of input capture cells that sit between I/O pins and a programmable logic array. Each cell takes one pin and, under a per-cell mode setting, either forwards it unchanged, holds it in a level-sensitive latch, or captures it in an edge-triggered register. The result of each cell feeds the logic array and can also be read by a host processor.

The gate that opens the latch or triggers the register is chosen per cell. It is either a product term from the logic array or the host processor's address-latch-enable strobe. The strobe option lets a cell grab address bits from a multiplexed address/data bus. All storage runs on one system clock. A register-mode capture is triggered by a rising edge of the selected gate, detected on that clock. Latch mode is transparent whenever the selected gate is high.

Top module: `imc_bank`

## Requirements
- R1: Mode code 2'b00 (bypass) drives `arr_out[i]` from `pin[i]` in the same cycle, whatever the gate does. The value held in storage is left unchanged.
- R2: In mode code 2'b01 (latch), while the selected gate is high, `arr_out[i]` follows `pin[i]` combinationally. At every clock edge with the gate high, the storage takes `pin[i]`.
- R3: In latch mode with the selected gate low, `arr_out[i]` holds the pin value that was sampled at the last clock edge at which the gate was high. Pin changes have no effect.
- R4: In mode code 2'b10 (register), storage takes `pin[i]` at the first clock edge at which the selected gate is seen high after having been low at the previous edge. `arr_out[i]` shows the stored value from the clock edge onward. It does not change at any other edge, including while the gate stays high.
- R5: `gate_sel[i]`=0 picks product term `pt_gate[i]` as the gate of cell i, and `gate_sel[i]`=1 picks the shared `ale` strobe. The source that is not picked has no effect.
- R6: A synchronous reset `rst` clears every stored value to 0 and clears the gate history. If the selected gate is high at the first clock edge after reset, that edge counts as a rising edge.
- R7: With `rd_en` high, `host_dout[i]` equals `arr_out[i]`. With `rd_en` low, `host_dout` is all zeros.
- R8: Mode code 2'b11 behaves as bypass.
- R9: Each cell uses only its own mode, gate select, product term and pin. Cells set to different modes operate independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cell_mode | input | 2*N | Mode code of cell i in bits [2i+1:2i] |
| gate_sel | input | N | Gate source per cell: 0 product term, 1 ale |
| pt_gate | input | N | Product-term gate, one per cell |
| ale | input | 1 | Host address-latch-enable strobe, shared |
| pin | input | N | Sampled I/O pin values |
| rd_en | input | 1 | Host read strobe |
| arr_out | output | N | Cell outputs to the logic array |
| host_dout | output | N | Cell outputs on the host data bus |

## Verification
Bypass and transparent-latch results, and the host read value, are combinational. They are checked one nanosecond after the inputs change, before the next clock edge. Register captures, latch hold values and reset effects take one clock edge. For these the bench changes inputs at the falling edge and samples one nanosecond after the following rising edge. The rising-edge rule depends on the gate level seen at the previous edge, so the stimulus table carries the gate history across rows, and each expected value is worked out from that history.

// File: rtl/imc_pkg.sv
package imc_pkg;

  typedef enum logic [1:0] {
    M_BYPASS = 2'b00,
    M_LATCH  = 2'b01,
    M_REG    = 2'b10,
    M_SPARE  = 2'b11
  } imc_mode_e;

  // Spare code is folded onto bypass.
  function automatic imc_mode_e decode_mode(input logic [1:0] code);
    case (code)
      2'b01:   decode_mode = M_LATCH;
      2'b10:   decode_mode = M_REG;
      default: decode_mode = M_BYPASS;
    endcase
  endfunction

  function automatic logic next_hold(input imc_mode_e m, input logic gate,
                                     input logic rise, input logic pin_v,
                                     input logic hold_v);
    case (m)
      M_LATCH: next_hold = gate ? pin_v : hold_v;
      M_REG:   next_hold = rise ? pin_v : hold_v;
      default: next_hold = hold_v;
    endcase
  endfunction

  function automatic logic cell_view(input imc_mode_e m, input logic gate,
                                     input logic pin_v, input logic hold_v);
    case (m)
      M_LATCH: cell_view = gate ? pin_v : hold_v;
      M_REG:   cell_view = hold_v;
      default: cell_view = pin_v;
    endcase
  endfunction

endpackage

// File: rtl/imc_gate_src.sv
module imc_gate_src (
  input  logic clk,
  input  logic rst,
  input  logic use_ale,
  input  logic pt_term,
  input  logic ale,
  output logic gate,
  output logic gate_rise
);
  logic gate_prev_q;

  assign gate = use_ale ? ale : pt_term;

  always_ff @(posedge clk) begin
    if (rst) gate_prev_q <= 1'b0;
    else     gate_prev_q <= gate;
  end

  assign gate_rise = gate & ~gate_prev_q;

  // R4: a rise is a single-cycle event
  a_r4_rise_single: assert property (@(posedge clk) disable iff (rst)
    gate_rise |=> !gate_rise);

endmodule

// File: rtl/imc_cell.sv
module imc_cell
  import imc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  imc_mode_e mode,
  input  logic      pin_v,
  input  logic      gate,
  input  logic      gate_rise,
  output logic      cell_out,
  output logic      hold_q
);

  always_ff @(posedge clk) begin
    if (rst) hold_q <= 1'b0;
    else     hold_q <= next_hold(mode, gate, gate_rise, pin_v, hold_q);
  end

  assign cell_out = cell_view(mode, gate, pin_v, hold_q);

  // R3: closed latch keeps its stored value
  a_r3_latch_hold: assert property (@(posedge clk) disable iff (rst)
    (mode == M_LATCH && !gate) |=> $stable(hold_q));

  // R4: capture on a detected gate rise
  a_r4_reg_capture: assert property (@(posedge clk) disable iff (rst)
    (mode == M_REG && gate_rise) |=> hold_q == $past(pin_v));

  // R4: no capture without a rise
  a_r4_reg_keep: assert property (@(posedge clk) disable iff (rst)
    (mode == M_REG && !gate_rise) |=> $stable(hold_q));

  // R1: bypass leaves storage alone
  a_r1_bypass_keep: assert property (@(posedge clk) disable iff (rst)
    (mode == M_BYPASS) |=> $stable(hold_q));

  // R6: reset clears storage
  a_r6_clear: assert property (@(posedge clk)
    rst |=> hold_q == 1'b0);

endmodule

// File: rtl/imc_rd_port.sv
module imc_rd_port #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_en,
  input  logic [N-1:0] data_in,
  output logic [N-1:0] dout
);
  assign dout = rd_en ? data_in : '0;

  // R7: idle bus reads as zero
  a_r7_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_en |-> dout == '0);

  // R7: strobe mirrors cell outputs
  a_r7_mirror: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> dout == data_in);

endmodule

// File: rtl/imc_bank.sv
module imc_bank
  import imc_pkg::*;
#(
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2*N-1:0] cell_mode,
  input  logic [N-1:0]   gate_sel,
  input  logic [N-1:0]   pt_gate,
  input  logic           ale,
  input  logic [N-1:0]   pin,
  input  logic           rd_en,
  output logic [N-1:0]   arr_out,
  output logic [N-1:0]   host_dout
);
  localparam int MW = 2;

  logic [N-1:0] gate_w;
  logic [N-1:0] rise_w;
  logic [N-1:0] hold_w;

  for (genvar i = 0; i < N; i++) begin : g_cell
    imc_mode_e mode_i;
    assign mode_i = decode_mode(cell_mode[MW*i +: MW]);

    imc_gate_src u_gate (
      .clk       (clk),
      .rst       (rst),
      .use_ale   (gate_sel[i]),
      .pt_term   (pt_gate[i]),
      .ale       (ale),
      .gate      (gate_w[i]),
      .gate_rise (rise_w[i])
    );

    imc_cell u_cell (
      .clk       (clk),
      .rst       (rst),
      .mode      (mode_i),
      .pin_v     (pin[i]),
      .gate      (gate_w[i]),
      .gate_rise (rise_w[i]),
      .cell_out  (arr_out[i]),
      .hold_q    (hold_w[i])
    );

    // R1 and R8: bypass and spare codes pass the pin through
    a_r1_bypass: assert property (@(posedge clk) disable iff (rst)
      (cell_mode[MW*i +: MW] == 2'b00 || cell_mode[MW*i +: MW] == 2'b11)
        |-> arr_out[i] == pin[i]);

    // R2: open latch is transparent
    a_r2_transparent: assert property (@(posedge clk) disable iff (rst)
      (cell_mode[MW*i +: MW] == 2'b01 && gate_w[i]) |-> arr_out[i] == pin[i]);
  end

  imc_rd_port #(.N(N)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .data_in (arr_out),
    .dout    (host_dout)
  );

endmodule

// File: tb/sim_imc_bank.sv
module sim_imc_bank;
  localparam int N = 4;

  logic           clk = 1'b0;
  logic           rst;
  logic [2*N-1:0] cell_mode;
  logic [N-1:0]   gate_sel;
  logic [N-1:0]   pt_gate;
  logic           ale;
  logic [N-1:0]   pin;
  logic           rd_en;
  logic [N-1:0]   arr_out;
  logic [N-1:0]   host_dout;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  imc_bank #(.N(N)) u0 (
    .clk(clk), .rst(rst), .cell_mode(cell_mode), .gate_sel(gate_sel),
    .pt_gate(pt_gate), .ale(ale), .pin(pin), .rd_en(rd_en),
    .arr_out(arr_out), .host_dout(host_dout)
  );

  // {mode, gate source, gate level, pin, expected after the edge}
  localparam int NV = 16;
  localparam logic [11:0] VEC [NV] = '{
    {2'b00, 1'b0, 1'b0, 4'hA, 4'hA},
    {2'b00, 1'b0, 1'b1, 4'h5, 4'h5},
    {2'b01, 1'b0, 1'b1, 4'h3, 4'h3},
    {2'b01, 1'b0, 1'b0, 4'hC, 4'h3},
    {2'b01, 1'b0, 1'b0, 4'hF, 4'h3},
    {2'b01, 1'b0, 1'b1, 4'h6, 4'h6},
    {2'b10, 1'b0, 1'b1, 4'h9, 4'h6},
    {2'b10, 1'b0, 1'b0, 4'h9, 4'h6},
    {2'b10, 1'b0, 1'b1, 4'h9, 4'h9},
    {2'b10, 1'b0, 1'b1, 4'h2, 4'h9},
    {2'b10, 1'b0, 1'b0, 4'h2, 4'h9},
    {2'b10, 1'b1, 1'b1, 4'h4, 4'h4},
    {2'b10, 1'b1, 1'b0, 4'h4, 4'h4},
    {2'b01, 1'b1, 1'b1, 4'hB, 4'hB},
    {2'b01, 1'b1, 1'b0, 4'h1, 4'hB},
    {2'b11, 1'b0, 1'b0, 4'h7, 4'h7}
  };

  task automatic chk(input string req, input logic [N-1:0] act,
                     input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Same gate level on the picked source, opposite level on the other one.
  task automatic drive(input logic [1:0] m, input logic gs, input logic g,
                       input logic [N-1:0] p);
    cell_mode = {N{m}};
    gate_sel  = {N{gs}};
    pt_gate   = gs ? {N{~g}} : {N{g}};
    ale       = gs ? g : ~g;
    pin       = p;
  endtask

  initial begin
    rst = 1'b1; rd_en = 1'b0;
    drive(2'b10, 1'b0, 1'b0, 4'h0);
    repeat (2) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    chk("R6 reset clears register output", arr_out, 4'h0);
    chk("R7 idle read is zero", host_dout, 4'h0);
    rd_en = 1'b1;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      drive(VEC[k][11:10], VEC[k][9], VEC[k][8], VEC[k][7:4]);
      @(posedge clk); #1;
      // R1 R3 R4 R5 R8 through the table
      chk($sformatf("R4/R3/R1/R5/R8 row %0d", k), arr_out, VEC[k][3:0]);
      chk($sformatf("R7 read row %0d", k), host_dout, VEC[k][3:0]);
    end

    // R2: transparent before any clock edge
    @(negedge clk);
    drive(2'b01, 1'b0, 1'b1, 4'h8); #1;
    chk("R2 latch follows pin", arr_out, 4'h8);
    pin = 4'h2; #1;
    chk("R2 latch follows pin change", arr_out, 4'h2);
    @(posedge clk);
    @(negedge clk) pt_gate = 4'h0; ale = 1'b1; pin = 4'hD; #1;
    chk("R3 latch closed holds", arr_out, 4'h2);

    // R1: bypass ignores gate activity and leaves storage alone
    @(negedge clk);
    drive(2'b00, 1'b0, 1'b1, 4'h6); #1;
    chk("R1 bypass same cycle", arr_out, 4'h6);
    @(posedge clk);
    @(negedge clk) drive(2'b01, 1'b0, 1'b0, 4'h0); #1;
    chk("R1 storage untouched by bypass", arr_out, 4'h2);

    // R7: strobe low gives zero
    rd_en = 1'b0; #1;
    chk("R7 strobe low", host_dout, 4'h0);
    rd_en = 1'b1;

    // R9: mixed modes across cells
    @(negedge clk);
    cell_mode = {2'b10, 2'b01, 2'b00, 2'b10};
    gate_sel  = 4'b0000;
    pt_gate   = 4'b0000;
    ale       = 1'b0;
    pin       = 4'hF;
    @(posedge clk);
    @(negedge clk) pt_gate = 4'b0001; pin = 4'b0101;
    @(posedge clk); #1;
    // cell0 reg rise->1, cell1 bypass->0, cell2 latch closed->hold 0, cell3 reg no rise->0
    chk("R9 independent cells", arr_out, 4'b0001);

    // R6: mid-run reset clears storage
    @(negedge clk);
    drive(2'b10, 1'b0, 1'b0, 4'hF);
    @(posedge clk);
    @(negedge clk) pt_gate = 4'hF;
    @(posedge clk); #1;
    chk("R4 capture before reset", arr_out, 4'hF);
    @(negedge clk) rst = 1'b1;
    @(posedge clk); #1;
    chk("R6 reset clears storage", arr_out, 4'h0);
    // gate still high when reset drops: first edge is a rise
    @(negedge clk) rst = 1'b0; pin = 4'h9;
    @(posedge clk); #1;
    chk("R6 gate history cleared", arr_out, 4'h9);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule